// File: doc/BRIEF.md
# Self-Healing Prefix Adder

This block is a purely combinational 16-bit adder that repairs a single faulty dot operator on every addition. A logarithmic-depth prefix tree with four levels of distance-doubling dot operators produces the primary carry vector. One further dot-operator stage rebuilds each carry a second time, using the primary carry of the bit just below it. Because the tree never mixes odd and even bit-paths after its first level, a fault on any tree operator can corrupt primary carries of only one parity class. That fault leaves the rebuilt carries of that same class intact.

The two carry vectors are compared bit by bit. If they agree, the sum uses the primary carries. If they disagree, the lowest disagreeing position shows which parity class is damaged. For that class the rebuilt carries replace the primary ones, while the other class keeps its primary carries. The decision is made again for every operand set. A transient upset therefore affects only the addition it occurs in, and a permanent defect is bypassed on every later addition. Any number of tree faults confined to one parity class are also corrected.

A fault-injection port lets a test force the generate output of any one dot operator to stuck-at-0, stuck-at-1 or inverted. The block has no clock and no state, so the house state-machine layout does not apply.

Top module: `selfheal_prefix_adder`

## Requirements
- R1: With `fault_mode` = 0, `{carry_out, sum_out}` equals `a_in + b_in + carry_in` for every operand combination.
- R2: With `fault_mode` = 0, `fault_detected` and `even_sel` are both 0. `even_sel` is 0 whenever `fault_detected` is 0.
- R3: `fault_mode` uses these codes: 0 = no fault, 1 = generate output stuck at 0, 2 = stuck at 1, 3 = inverted. `fault_level` values 0..3 select the tree level whose operators span a distance of 2^level. Value 4 selects the rebuild stage. `fault_index` is the bit position of the operator. A site that has no operator (tree index below 2^level, rebuild index 0, or level 5..7) leaves every output equal to the no-fault result.
- R4: With any single fault on any tree operator (levels 0..3, any mode), `{carry_out, sum_out}` equals `a_in + b_in + carry_in` for all operands.
- R5: With a stuck-at-1 or inverted fault on a tree operator at position j, and operands 0 + 0 with carry-in 0, `fault_detected` is 1. `even_sel` is 1 exactly when j is even.
- R6: With a stuck-at-1 or inverted fault on the rebuild-stage operator at position j, and operands 0 + 0 with carry-in 0, `fault_detected` is 1. `even_sel` is 1 exactly when j is even.
- R7: Under any single injected fault, including one in the rebuild stage, `fault_detected` = 0 implies that `{carry_out, sum_out}` equals `a_in + b_in + carry_in`.
- R8: `carry_out` is taken from the repaired carry vector. With `a_in` = 16'hFFFF, `b_in` = 0 and `carry_in` = 1, the result is `carry_out` = 1 and `sum_out` = 0 under any single tree fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| fault_mode | input | 2 | Injected fault kind: 0 none, 1 stuck-0, 2 stuck-1, 3 invert |
| fault_level | input | 3 | Operator level: 0..3 tree, 4 rebuild stage |
| fault_index | input | 4 | Bit position of the faulted operator |
| sum_out | output | 16 | Repaired sum |
| carry_out | output | 1 | Repaired carry out of bit 15 |
| fault_detected | output | 1 | The two carry vectors disagree |
| even_sel | output | 1 | Lowest disagreeing carry is at an even position |

## Verification
The block holds no state, so a wrong internal carry shows up in the same evaluation that applies the operands. It appears either as a flipped sum bit at the first position above the bad carry, or as a wrong `carry_out`. A broken comparison or parity pick shows up as a wrong `fault_detected` or `even_sel` for zero operands with a stuck-at-1 site. It also shows up as a wrong sum for whichever faults the mis-steered class fails to repair. The sweep therefore visits every operator site in every mode, with edge and random operands.

// File: rtl/shpa_pkg.sv
package shpa_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_STUCK0 = 2'd1,
        FLT_STUCK1 = 2'd2,
        FLT_FLIP   = 2'd3
    } flt_mode_e;

    // Apply the selected fault to one generate output when the site matches.
    function automatic logic inject(input logic raw, input logic [1:0] mode, input logic hit);
        logic res;
        res = raw;
        if (hit) begin
            unique case (mode)
                FLT_NONE:   res = raw;
                FLT_STUCK0: res = 1'b0;
                FLT_STUCK1: res = 1'b1;
                FLT_FLIP:   res = ~raw;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/shpa_pg_stage.sv
module shpa_pg_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    logic [WIDTH-1:0] gen_raw;

    assign prop    = a ^ b;
    assign gen_raw = a & b;
    // Carry-in folded into bit 0 so the prefix tree needs no extra column.
    assign gen     = {gen_raw[WIDTH-1:1], gen_raw[0] | (prop[0] & cin)};
endmodule

// File: rtl/shpa_ks_tree.sv
module shpa_ks_tree #(
    parameter int WIDTH  = 16,
    parameter int LEVELS = $clog2(WIDTH),
    parameter int LW     = $clog2(LEVELS + 1),
    parameter int IW     = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic [1:0]       flt_mode,
    input  logic [LW-1:0]    flt_level,
    input  logic [IW-1:0]    flt_index,
    output logic [WIDTH-1:0] c_ks
);
    logic [LEVELS:0][WIDTH-1:0] gv;
    logic [LEVELS:0][WIDTH-1:0] pv;

    assign gv[0] = gen;
    assign pv[0] = prop;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int DIST = 1 << l;
        localparam logic [LW-1:0] LV = LW'(l);
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i >= DIST) begin : g_dot
                localparam logic [IW-1:0] IX = IW'(i);
                logic hit;
                logic g_raw;
                assign hit   = (flt_level == LV) && (flt_index == IX);
                assign g_raw = gv[l][i] | (pv[l][i] & gv[l][i-DIST]);
                assign gv[l+1][i] = shpa_pkg::inject(g_raw, flt_mode, hit);
                assign pv[l+1][i] = pv[l][i] & pv[l][i-DIST];
            end else begin : g_pass
                assign gv[l+1][i] = gv[l][i];
                assign pv[l+1][i] = pv[l][i];
            end
        end
    end

    assign c_ks = gv[LEVELS];
endmodule

// File: rtl/shpa_hc_stage.sv
module shpa_hc_stage #(
    parameter int WIDTH  = 16,
    parameter int LEVELS = $clog2(WIDTH),
    parameter int LW     = $clog2(LEVELS + 1),
    parameter int IW     = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] c_ks,
    input  logic [1:0]       flt_mode,
    input  logic [LW-1:0]    flt_level,
    input  logic [IW-1:0]    flt_index,
    output logic [WIDTH-1:0] c_hc
);
    localparam logic [LW-1:0] LV = LW'(LEVELS);

    // Position 0 has no operator: its carry is the folded generate itself.
    assign c_hc[0] = gen[0];

    for (genvar i = 1; i < WIDTH; i++) begin : g_bit
        localparam logic [IW-1:0] IX = IW'(i);
        logic hit;
        logic g_raw;
        assign hit     = (flt_level == LV) && (flt_index == IX);
        assign g_raw   = gen[i] | (prop[i] & c_ks[i-1]);
        assign c_hc[i] = shpa_pkg::inject(g_raw, flt_mode, hit);
    end
endmodule

// File: rtl/shpa_steer.sv
module shpa_steer #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] c_ks,
    input  logic [WIDTH-1:0] c_hc,
    output logic [WIDTH-1:0] c_fix,
    output logic             mismatch,
    output logic             low_even
);
    logic [WIDTH-1:0] err;
    logic             found;

    assign err      = c_ks ^ c_hc;
    assign mismatch = |err;

    // Only the parity bit of a priority encode over err is needed.
    always_comb begin
        found    = 1'b0;
        low_even = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (!found && err[i]) begin
                found    = 1'b1;
                low_even = ((i % 2) == 0);
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_mux
        localparam logic EVEN_POS = ((i % 2) == 0);
        assign c_fix[i] = (mismatch && (EVEN_POS == low_even)) ? c_hc[i] : c_ks[i];
    end
endmodule

// File: rtl/selfheal_prefix_adder.sv
module selfheal_prefix_adder #(
    parameter int WIDTH  = 16,
    parameter int LEVELS = $clog2(WIDTH),
    parameter int LW     = $clog2(LEVELS + 1),
    parameter int IW     = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    input  logic [1:0]       fault_mode,
    input  logic [LW-1:0]    fault_level,
    input  logic [IW-1:0]    fault_index,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             fault_detected,
    output logic             even_sel
);
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] c_ks;
    logic [WIDTH-1:0] c_hc;
    logic [WIDTH-1:0] c_fix;

    shpa_pg_stage #(.WIDTH(WIDTH)) u_pg (
        .a    (a_in),
        .b    (b_in),
        .cin  (carry_in),
        .gen  (gen),
        .prop (prop)
    );

    shpa_ks_tree #(.WIDTH(WIDTH), .LEVELS(LEVELS), .LW(LW), .IW(IW)) u_tree (
        .gen       (gen),
        .prop      (prop),
        .flt_mode  (fault_mode),
        .flt_level (fault_level),
        .flt_index (fault_index),
        .c_ks      (c_ks)
    );

    shpa_hc_stage #(.WIDTH(WIDTH), .LEVELS(LEVELS), .LW(LW), .IW(IW)) u_rebuild (
        .gen       (gen),
        .prop      (prop),
        .c_ks      (c_ks),
        .flt_mode  (fault_mode),
        .flt_level (fault_level),
        .flt_index (fault_index),
        .c_hc      (c_hc)
    );

    shpa_steer #(.WIDTH(WIDTH)) u_steer (
        .c_ks     (c_ks),
        .c_hc     (c_hc),
        .c_fix    (c_fix),
        .mismatch (fault_detected),
        .low_even (even_sel)
    );

    assign sum_out   = prop ^ {c_fix[WIDTH-2:0], carry_in};
    assign carry_out = c_fix[WIDTH-1];
endmodule

// File: rtl/selfheal_prefix_adder_chk.sv
module selfheal_prefix_adder_chk #(
    parameter int WIDTH  = 16,
    parameter int LEVELS = $clog2(WIDTH),
    parameter int LW     = $clog2(LEVELS + 1),
    parameter int IW     = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             carry_in,
    input logic [1:0]       fault_mode,
    input logic [LW-1:0]    fault_level,
    input logic [IW-1:0]    fault_index,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             fault_detected,
    input logic             even_sel
);
    logic [WIDTH:0] ref_sum;
    logic           sum_ok;

    assign ref_sum = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};
    assign sum_ok  = ({carry_out, sum_out} == ref_sum);

    always_comb begin
        if (fault_mode == 2'd0) begin
            assert_clean_sum_R1: assert (sum_ok);
            assert_quiet_flags_R2: assert (!fault_detected);
        end
        if (!fault_detected) begin
            assert_no_parity_without_fault_R2: assert (!even_sel);
            assert_undetected_is_correct_R7: assert (sum_ok);
        end
        if (fault_level < LW'(LEVELS)) begin
            assert_tree_fault_repaired_R4: assert (sum_ok);
        end
    end
endmodule

bind selfheal_prefix_adder selfheal_prefix_adder_chk #(
    .WIDTH(WIDTH), .LEVELS(LEVELS), .LW(LW), .IW(IW)
) u_chk (
    .a_in           (a_in),
    .b_in           (b_in),
    .carry_in       (carry_in),
    .fault_mode     (fault_mode),
    .fault_level    (fault_level),
    .fault_index    (fault_index),
    .sum_out        (sum_out),
    .carry_out      (carry_out),
    .fault_detected (fault_detected),
    .even_sel       (even_sel)
);

// File: tb/tb_selfheal_prefix_adder.sv
`timescale 1ns/1ps
module tb_selfheal_prefix_adder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a_in, b_in;
    logic         carry_in;
    logic [1:0]   fault_mode;
    logic [2:0]   fault_level;
    logic [3:0]   fault_index;
    logic [W-1:0] sum_out;
    logic         carry_out, fault_detected, even_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    selfheal_prefix_adder dut (
        .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
        .fault_mode(fault_mode), .fault_level(fault_level), .fault_index(fault_index),
        .sum_out(sum_out), .carry_out(carry_out),
        .fault_detected(fault_detected), .even_sel(even_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b mode=%0d lvl=%0d idx=%0d)",
                     req, act, exp, a_in, b_in, carry_in, fault_mode, fault_level, fault_index);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                         input logic [1:0] m, input logic [2:0] l, input logic [3:0] i);
        @(posedge clk);
        {a_in, b_in, carry_in, fault_mode, fault_level, fault_index} = {a, b, c, m, l, i};
        @(negedge clk);
    endtask

    function automatic logic [31:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        return 32'({1'b0, a} + {1'b0, b} + {{W{1'b0}}, c});
    endfunction

    task automatic pick(input int k, output logic [W-1:0] a, output logic [W-1:0] b, output logic c);
        case (k)
            0: begin a = '0;        b = '0;        c = 1'b0; end
            1: begin a = '1;        b = '0;        c = 1'b1; end
            2: begin a = '1;        b = '1;        c = 1'b1; end
            3: begin a = 16'hAAAA;  b = 16'h5555;  c = 1'b1; end
            4: begin a = 16'h5555;  b = 16'h5555;  c = 1'b0; end
            5: begin a = 16'h8000;  b = 16'h8000;  c = 1'b0; end
            default: begin a = W'($urandom); b = W'($urandom); c = 1'($urandom); end
        endcase
    endtask

    localparam int NVEC = 46;

    initial begin
        logic [W-1:0] a, b;
        logic         c;
        {a_in, b_in, carry_in, fault_mode, fault_level, fault_index} = '0;

        // Idle state with zero inputs: no fault raised.
        @(negedge clk);
        check("R2 idle detect", 32'(fault_detected), 0);
        check("R1 idle sum", 32'({carry_out, sum_out}), 0);

        // No fault, many operand patterns.
        for (int k = 0; k < 400; k++) begin
            pick(k, a, b, c);
            apply(a, b, c, 2'd0, 3'($urandom), 4'($urandom));
            check("R1 clean sum", 32'({carry_out, sum_out}), ref_add(a, b, c));
            check("R2 clean flags", 32'({fault_detected, even_sel}), 0);
        end

        // Sites without an operator have no effect.
        apply('0, '0, 1'b0, 2'd2, 3'd1, 4'd0);
        check("R3 absent site level1 idx0", 32'({carry_out, sum_out, fault_detected, even_sel}), 0);
        apply('0, '0, 1'b0, 2'd2, 3'd3, 4'd7);
        check("R3 absent site level3 idx7", 32'({fault_detected, even_sel}), 0);
        apply('0, '0, 1'b0, 2'd3, 3'd4, 4'd0);
        check("R3 absent rebuild idx0", 32'({fault_detected, even_sel}), 0);
        apply('0, '0, 1'b0, 2'd2, 3'd6, 4'd9);
        check("R3 unused level 6", 32'({carry_out, sum_out, fault_detected}), 0);

        // Every tree site in every fault mode.
        for (int l = 0; l < 4; l++) begin
            for (int j = (1 << l); j < W; j++) begin
                for (int m = 1; m < 4; m++) begin
                    for (int k = 0; k < NVEC; k++) begin
                        pick(k, a, b, c);
                        apply(a, b, c, 2'(m), 3'(l), 4'(j));
                        check("R4 tree fault sum", 32'({carry_out, sum_out}), ref_add(a, b, c));
                    end
                    if (m != 1) begin
                        apply('0, '0, 1'b0, 2'(m), 3'(l), 4'(j));
                        check("R5 tree detect", 32'(fault_detected), 1);
                        check("R5 tree parity", 32'(even_sel), 32'((j % 2) == 0));
                    end
                    apply('1, '0, 1'b1, 2'(m), 3'(l), 4'(j));
                    check("R8 carry_out repaired", 32'({carry_out, sum_out}), 32'h1_0000);
                end
            end
        end

        // Every rebuild-stage site: detection and soundness when undetected.
        for (int j = 1; j < W; j++) begin
            for (int m = 1; m < 4; m++) begin
                for (int k = 0; k < NVEC; k++) begin
                    pick(k, a, b, c);
                    apply(a, b, c, 2'(m), 3'd4, 4'(j));
                    if (!fault_detected)
                        check("R7 undetected correct", 32'({carry_out, sum_out}), ref_add(a, b, c));
                end
                if (m != 1) begin
                    apply('0, '0, 1'b0, 2'(m), 3'd4, 4'(j));
                    check("R6 rebuild detect", 32'(fault_detected), 1);
                    check("R6 rebuild parity", 32'(even_sel), 32'((j % 2) == 0));
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule